// File: doc/BRIEF.md
# DSP Memory-Map Bank Controller

This block sits on the external bus of a 16-bit DSP. The DSP has three separate active-low space strobes: program, data and I/O. From these strobes and the address, the block works out which external device answers each cycle. It drives the chip enable of a 512K x 16 flash and the paired enables of a 128K x 16 SRAM, which is built from two byte-wide parts. It also produces active-low selects for a codec register chip and a UART that share I/O space.

Both memories are larger than one 64K-word space. The block therefore supplies their upper address bits from page registers, which the DSP writes through I/O space. A third register chooses whether program-space cycles reach the flash or the SRAM. Data space always reaches the SRAM. Firmware uses this to copy code from the slow flash into the fast SRAM one page at a time, and then switches program space over to the SRAM.

To save power, a bus-enable input parks the block. While the input is low, no select asserts, writes are refused and all register contents are held.

Top module: `dsp_bank_ctrl`

## Requirements
- R1: After reset, program space maps to flash, both page fields read 0, and every chip select is inactive (flash_ce_no=1, sram_ce1_no=1, sram_ce2_o=0, codec_cs_no=1, uart_cs_no=1).
- R2: When ps_ni, ds_ni and is_ni are all high, or when more than one of them is low, no chip select asserts and rd_oe_o stays 0.
- R3: A program-space cycle asserts flash_ce_no when the program-map bit is 0, and asserts the SRAM enables when the bit is 1. Flash and SRAM are never enabled in the same cycle.
- R4: A data-space cycle enables only the SRAM: sram_ce1_no goes low and sram_ce2_o goes high together. Flash is never enabled in data space.
- R5: flash_page_o always shows the 3-bit flash page field, and sram_page_o always shows the 1-bit SRAM page field.
- R6: A register write takes place on the clock edge that first sees wr_ni high after a cycle in which wr_ni and is_ni were both low. The write uses the address and data of that earlier cycle. Offset 0x0000 bit 0 is the program-map bit (0 = flash, 1 = SRAM). Offset 0x0001 bits 2:0 are the flash page. Offset 0x0002 bit 0 is the SRAM page. Writes to 0x0003–0x000F, or to any address outside 0x0000–0x000F, change nothing.
- R7: An I/O read with rd_ni low at 0x0000–0x000F sets rd_oe_o to 1 and returns the register value on rdata_o, with unused bits 0. Offsets 0x0003–0x000F read as 0. In every other cycle, rdata_o is 0 and rd_oe_o is 0.
- R8: In I/O space, codec_cs_no is low for addresses 0x0100–0x01FF and uart_cs_no is low for addresses 0x0200–0x0207. Both stay high for every other address and in every other space.
- R9: While bus_en_i is low, every select is inactive, rd_oe_o is 0, and register writes are ignored. The previous register values are still in place once bus_en_i returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | Bus enable; low parks the block |
| ps_ni | input | 1 | Program-space strobe, active low |
| ds_ni | input | 1 | Data-space strobe, active low |
| is_ni | input | 1 | I/O-space strobe, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | 16 | DSP address |
| wdata_i | input | 16 | DSP write data |
| rdata_o | output | 16 | Register read data |
| rd_oe_o | output | 1 | High while rdata_o should drive the bus |
| flash_ce_no | output | 1 | Flash chip enable, active low |
| flash_page_o | output | 3 | Flash address bits 18:16 |
| sram_ce1_no | output | 1 | SRAM enable, active low, to both byte parts |
| sram_ce2_o | output | 1 | SRAM enable, active high, to both byte parts |
| sram_page_o | output | 1 | SRAM address bit 16 |
| codec_cs_no | output | 1 | Codec register chip select, active low |
| uart_cs_no | output | 1 | UART chip select, active low |

## Verification
Some properties are checked by assertions on every cycle:
- flash and SRAM are never enabled together;
- flash never answers a data-space cycle;
- the selects stay quiet when no single strobe is low;
- all selects are inactive when the bus is disabled;
- the page and mode fields do not change while bus_en_i is low.

Other behaviour can only be shown by the bench scenarios, which compare each output against a behavioural model on every clock. These cover the write-on-rising-strobe timing, the read-back values with zeroed unused bits, the exact edges of the codec and UART windows, and the register contents surviving a disabled period.

// File: rtl/dsp_bank_pkg.sv
`timescale 1ns/1ps
package dsp_bank_pkg;
  parameter int FPG_W = 3;
  parameter int SPG_W = 1;
  parameter int CAP_W = (FPG_W > SPG_W) ? FPG_W : SPG_W;

  parameter int OFF_MODE  = 0;
  parameter int OFF_FPAGE = 1;
  parameter int OFF_SPAGE = 2;

  typedef enum logic {
    PGM_FLASH = 1'b0,
    PGM_SRAM  = 1'b1
  } pgm_sel_e;

  typedef enum logic [1:0] {
    SP_NONE = 2'd0,
    SP_PGM  = 2'd1,
    SP_DATA = 2'd2,
    SP_IO   = 2'd3
  } space_e;

  typedef struct packed {
    pgm_sel_e          pgm;
    logic [FPG_W-1:0]  fpg;
    logic [SPG_W-1:0]  spg;
  } cfg_t;

  parameter cfg_t CFG_RST = '{pgm: PGM_FLASH, fpg: '0, spg: '0};
endpackage

// File: rtl/dsp_bank_win.sv
`timescale 1ns/1ps
// Aligned power-of-two address window match on the upper address bits.
module dsp_bank_win #(
  parameter int                ADDR_W = 16,
  parameter int                AW     = 4,
  parameter logic [ADDR_W-1:0] BASE   = '0
) (
  input  logic [ADDR_W-AW-1:0] addr_hi_i,
  output logic                 hit_o
);
  localparam logic [ADDR_W-AW-1:0] TAG = BASE[ADDR_W-1:AW];
  assign hit_o = (addr_hi_i == TAG);
endmodule

// File: rtl/dsp_bank_regs.sv
`timescale 1ns/1ps
module dsp_bank_regs
  import dsp_bank_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int REG_AW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_en_i,
  input  logic              is_ni,
  input  logic              wr_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output cfg_t              cfg_o,
  output logic [DATA_W-1:0] rd_val_o
);
  localparam logic [REG_AW-1:0] A_MODE  = REG_AW'(OFF_MODE);
  localparam logic [REG_AW-1:0] A_FPAGE = REG_AW'(OFF_FPAGE);
  localparam logic [REG_AW-1:0] A_SPAGE = REG_AW'(OFF_SPAGE);

  logic              wr_q, is_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CAP_W-1:0]  data_q;
  logic              wr_rise, win_q, commit;
  cfg_t              cfg_q;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[DATA_W-1:CAP_W];

  // Previous-cycle bus snapshot; the write lands on the strobe's rising edge.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= 1'b1;
      is_q   <= 1'b1;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      wr_q   <= wr_ni;
      is_q   <= is_ni;
      addr_q <= addr_i;
      data_q <= wdata_i[CAP_W-1:0];
    end
  end

  assign wr_rise = !wr_q && wr_ni;
  assign win_q   = (addr_q[ADDR_W-1:REG_AW] == '0);
  assign commit  = bus_en_i && wr_rise && !is_q && win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RST;
    end else if (commit) begin
      unique case (addr_q[REG_AW-1:0])
        A_MODE:  cfg_q.pgm <= pgm_sel_e'(data_q[0]);
        A_FPAGE: cfg_q.fpg <= data_q[FPG_W-1:0];
        A_SPAGE: cfg_q.spg <= data_q[SPG_W-1:0];
        default: ;
      endcase
    end
  end

  assign cfg_o = cfg_q;

  always_comb begin
    rd_val_o = '0;
    unique case (addr_i[REG_AW-1:0])
      A_MODE:  rd_val_o[0]         = cfg_q.pgm;
      A_FPAGE: rd_val_o[FPG_W-1:0] = cfg_q.fpg;
      A_SPAGE: rd_val_o[SPG_W-1:0] = cfg_q.spg;
      default: ;
    endcase
  end

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_en_i |=> $stable(cfg_q));

  p_noedge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_q || !wr_ni) |=> $stable(cfg_q));
endmodule

// File: rtl/dsp_bank_decode.sv
`timescale 1ns/1ps
module dsp_bank_decode
  import dsp_bank_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                REG_AW     = 4,
  parameter logic [ADDR_W-1:0] CODEC_BASE = 16'h0100,
  parameter int                CODEC_AW   = 8,
  parameter logic [ADDR_W-1:0] UART_BASE  = 16'h0200,
  parameter int                UART_AW    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_en_i,
  input  logic              ps_ni,
  input  logic              ds_ni,
  input  logic              is_ni,
  input  logic              rd_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  pgm_sel_e          pgm_i,
  output logic              flash_ce_no,
  output logic              sram_ce1_no,
  output logic              sram_ce2_o,
  output logic              codec_cs_no,
  output logic              uart_cs_no,
  output logic              reg_rd_o
);
  localparam int NWIN = 3;
  localparam int WIN_REG = 0, WIN_CODEC = 1, WIN_UART = 2;
  localparam int                WIN_AW   [NWIN] = '{REG_AW, CODEC_AW, UART_AW};
  localparam logic [ADDR_W-1:0] WIN_BASE [NWIN] = '{'0, CODEC_BASE, UART_BASE};

  logic [NWIN-1:0] hit;
  space_e          space;
  logic            io, flash_sel, sram_sel;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    dsp_bank_win #(
      .ADDR_W (ADDR_W),
      .AW     (WIN_AW[g]),
      .BASE   (WIN_BASE[g])
    ) u_win (
      .addr_hi_i (addr_i[ADDR_W-1:WIN_AW[g]]),
      .hit_o     (hit[g])
    );
  end

  // Strobes decode only when exactly one is low; otherwise no space.
  always_comb begin
    space = SP_NONE;
    if (bus_en_i) begin
      unique case ({ps_ni, ds_ni, is_ni})
        3'b011:  space = SP_PGM;
        3'b101:  space = SP_DATA;
        3'b110:  space = SP_IO;
        default: space = SP_NONE;
      endcase
    end
  end

  assign io        = (space == SP_IO);
  assign flash_sel = (space == SP_PGM) && (pgm_i == PGM_FLASH);
  assign sram_sel  = ((space == SP_PGM) && (pgm_i == PGM_SRAM)) || (space == SP_DATA);

  assign flash_ce_no = !flash_sel;
  assign sram_ce1_no = !sram_sel;
  assign sram_ce2_o  = sram_sel;
  assign codec_cs_no = !(io && hit[WIN_CODEC]);
  assign uart_cs_no  = !(io && hit[WIN_UART]);
  assign reg_rd_o    = io && !rd_ni && hit[WIN_REG];

  p_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!flash_ce_no && !sram_ce1_no));

  p_ds_noflash_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ds_ni |-> flash_ce_no);

  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones({ps_ni, ds_ni, is_ni}) != 2) |->
      (flash_ce_no && sram_ce1_no && !sram_ce2_o && codec_cs_no && uart_cs_no && !reg_rd_o));

  p_busoff_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_en_i |->
      (flash_ce_no && sram_ce1_no && !sram_ce2_o && codec_cs_no && uart_cs_no && !reg_rd_o));

  p_io_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({!codec_cs_no, !uart_cs_no, reg_rd_o}));
endmodule

// File: rtl/dsp_bank_ctrl.sv
`timescale 1ns/1ps
module dsp_bank_ctrl
  import dsp_bank_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 16,
  parameter int                REG_AW     = 4,
  parameter logic [ADDR_W-1:0] CODEC_BASE = 16'h0100,
  parameter int                CODEC_AW   = 8,
  parameter logic [ADDR_W-1:0] UART_BASE  = 16'h0200,
  parameter int                UART_AW    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_en_i,
  input  logic              ps_ni,
  input  logic              ds_ni,
  input  logic              is_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rd_oe_o,
  output logic              flash_ce_no,
  output logic [FPG_W-1:0]  flash_page_o,
  output logic              sram_ce1_no,
  output logic              sram_ce2_o,
  output logic [SPG_W-1:0]  sram_page_o,
  output logic              codec_cs_no,
  output logic              uart_cs_no
);
  cfg_t              cfg;
  logic [DATA_W-1:0] rd_val;
  logic              reg_rd;

  dsp_bank_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .REG_AW (REG_AW)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bus_en_i (bus_en_i),
    .is_ni    (is_ni),
    .wr_ni    (wr_ni),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .cfg_o    (cfg),
    .rd_val_o (rd_val)
  );

  dsp_bank_decode #(
    .ADDR_W     (ADDR_W),
    .REG_AW     (REG_AW),
    .CODEC_BASE (CODEC_BASE),
    .CODEC_AW   (CODEC_AW),
    .UART_BASE  (UART_BASE),
    .UART_AW    (UART_AW)
  ) u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_en_i    (bus_en_i),
    .ps_ni       (ps_ni),
    .ds_ni       (ds_ni),
    .is_ni       (is_ni),
    .rd_ni       (rd_ni),
    .addr_i      (addr_i),
    .pgm_i       (cfg.pgm),
    .flash_ce_no (flash_ce_no),
    .sram_ce1_no (sram_ce1_no),
    .sram_ce2_o  (sram_ce2_o),
    .codec_cs_no (codec_cs_no),
    .uart_cs_no  (uart_cs_no),
    .reg_rd_o    (reg_rd)
  );

  assign flash_page_o = cfg.fpg;
  assign sram_page_o  = cfg.spg;
  assign rd_oe_o      = reg_rd;
  assign rdata_o      = reg_rd ? rd_val : '0;

  p_rdq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_oe_o |-> (rdata_o == '0));

  p_ce_pair_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_ce2_o == !sram_ce1_no);
endmodule

// File: tb/dsp_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module dsp_bank_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 1'b1;
  logic ps_n = 1'b1, ds_n = 1'b1, is_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [15:0] addr = '0, wdata = '0;
  logic [15:0] rdata;
  logic rd_oe, flash_ce_n, sram_ce1_n, sram_ce2, codec_cs_n, uart_cs_n;
  logic [2:0] flash_page;
  logic [0:0] sram_page;

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural model state
  int m_mode = 0, m_fpg = 0, m_spg = 0;
  int p_wr = 1, p_is = 1, p_addr = 0, p_data = 0;

  always #10 clk = ~clk;

  dsp_bank_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_en_i(bus_en),
    .ps_ni(ps_n), .ds_ni(ds_n), .is_ni(is_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rd_oe_o(rd_oe),
    .flash_ce_no(flash_ce_n), .flash_page_o(flash_page),
    .sram_ce1_no(sram_ce1_n), .sram_ce2_o(sram_ce2), .sram_page_o(sram_page),
    .codec_cs_no(codec_cs_n), .uart_cs_no(uart_cs_n)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=0x%0h exp=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Model: write lands on the edge that sees the strobe return high.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_fpg = 0; m_spg = 0;
      p_wr = 1; p_is = 1; p_addr = 0; p_data = 0;
    end else begin
      if (bus_en && p_wr == 0 && wr_n && p_is == 0 && p_addr < 16) begin
        if (p_addr == 0) m_mode = p_data & 1;
        else if (p_addr == 1) m_fpg = p_data & 7;
        else if (p_addr == 2) m_spg = p_data & 1;
      end
      p_wr = wr_n; p_is = is_n; p_addr = addr; p_data = wdata;
    end
  end

  // Every-cycle comparison, away from the edge.
  always @(posedge clk) begin
    int lows, e_fl, e_sr, e_co, e_ua, e_oe, e_rd;
    string tg;
    #2;
    lows = (ps_n ? 0 : 1) + (ds_n ? 0 : 1) + (is_n ? 0 : 1);
    e_fl = 0; e_sr = 0; e_co = 0; e_ua = 0; e_oe = 0; e_rd = 0;
    if (rst_n && bus_en && lows == 1) begin
      if (!ps_n) begin e_fl = (m_mode == 0); e_sr = (m_mode == 1); end
      if (!ds_n) e_sr = 1;
      if (!is_n) begin
        e_co = (addr >= 16'h0100 && addr <= 16'h01FF);
        e_ua = (addr >= 16'h0200 && addr <= 16'h0207);
        if (!rd_n && addr < 16) begin
          e_oe = 1;
          e_rd = (addr == 0) ? m_mode : (addr == 1) ? m_fpg : (addr == 2) ? m_spg : 0;
        end
      end
    end
    if (!rst_n) tg = "R1";
    else if (!bus_en) tg = "R9";
    else if (lows != 1) tg = "R2";
    else tg = "";
    chk((tg != "") ? tg : "R3", flash_ce_n, !e_fl);
    chk((tg != "") ? tg : "R4", sram_ce1_n, !e_sr);
    chk((tg != "") ? tg : "R4", sram_ce2, e_sr);
    chk((tg != "") ? tg : "R8", codec_cs_n, !e_co);
    chk((tg != "") ? tg : "R8", uart_cs_n, !e_ua);
    chk((tg != "") ? tg : "R7", rd_oe, e_oe);
    chk((tg != "") ? tg : "R7", rdata, e_rd);
    chk(!rst_n ? "R1" : "R5", flash_page, m_fpg);
    chk(!rst_n ? "R1" : "R5", sram_page, m_spg);
  end

  task automatic drive(bit p, bit d, bit i, bit r, bit w, logic [15:0] a, logic [15:0] dv, int n);
    @(negedge clk);
    ps_n = p; ds_n = d; is_n = i; rd_n = r; wr_n = w; addr = a; wdata = dv;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic idle(int n);
    drive(1, 1, 1, 1, 1, addr, wdata, n);
  endtask

  task automatic io_write(logic [15:0] a, logic [15:0] dv);
    drive(1, 1, 0, 1, 0, a, dv, 2);
    drive(1, 1, 0, 1, 1, a, dv, 1);
    idle(1);
  endtask

  task automatic io_read(logic [15:0] a, int exp, string tag);
    drive(1, 1, 0, 0, 1, a, 16'h0, 1);
    @(posedge clk); #3;
    chk(tag, rdata, exp);
    idle(1);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #3;
    chk("R1", flash_ce_n, 1); chk("R1", sram_ce2, 0);
    chk("R1", flash_page, 0); chk("R1", sram_page, 0);
    @(negedge clk); rst_n = 1;
    idle(3);
    io_read(16'h0000, 0, "R1");
    // R3 program space on flash
    drive(0, 1, 1, 0, 1, 16'h1234, 0, 3);
    // R2 more than one strobe low
    drive(0, 0, 1, 0, 1, 16'h0000, 0, 2);
    drive(1, 0, 0, 0, 1, 16'h0001, 0, 2);
    // R4 data space on SRAM
    drive(1, 0, 1, 0, 1, 16'hBEEF, 0, 3);
    // R6 writes
    io_write(16'h0001, 16'hFFFD);
    io_read(16'h0001, 5, "R6");
    io_write(16'h0002, 16'h0001);
    io_read(16'h0002, 1, "R6");
    io_write(16'h0000, 16'h0001);
    io_read(16'h0000, 1, "R6");
    drive(0, 1, 1, 0, 1, 16'h0042, 0, 3);
    drive(1, 0, 1, 1, 0, 16'h0042, 16'h5555, 2);
    // R6 writes outside register set
    io_write(16'h0003, 16'h0007);
    io_write(16'h000F, 16'h0007);
    io_write(16'h0101, 16'h0000);
    io_write(16'h0010, 16'h0000);
    io_read(16'h0003, 0, "R7");
    io_read(16'h000F, 0, "R7");
    io_read(16'h0000, 1, "R6");
    io_read(16'h0001, 5, "R6");
    // R7 wide write, unused bits read zero
    io_write(16'h0001, 16'hFFFF);
    io_read(16'h0001, 7, "R7");
    io_read(16'h0010, 0, "R7");
    // R8 window edges
    drive(1, 1, 0, 1, 1, 16'h00FF, 0, 1);
    drive(1, 1, 0, 1, 1, 16'h0100, 0, 1);
    drive(1, 1, 0, 1, 1, 16'h01FF, 0, 1);
    drive(1, 1, 0, 1, 1, 16'h0200, 0, 1);
    drive(1, 1, 0, 1, 1, 16'h0207, 0, 1);
    drive(1, 1, 0, 1, 1, 16'h0208, 0, 1);
    drive(1, 0, 1, 1, 1, 16'h0100, 0, 1);
    drive(0, 1, 1, 1, 1, 16'h0200, 0, 1);
    idle(1);
    // R9 bus disabled
    @(negedge clk); bus_en = 0;
    io_write(16'h0000, 16'h0000);
    io_write(16'h0001, 16'h0002);
    io_write(16'h0002, 16'h0000);
    drive(0, 1, 1, 1, 1, 16'h0000, 0, 2);
    drive(1, 0, 1, 1, 1, 16'h0000, 0, 2);
    drive(1, 1, 0, 0, 1, 16'h0000, 0, 2);
    drive(1, 1, 0, 1, 1, 16'h0100, 0, 2);
    @(negedge clk); bus_en = 1;
    idle(1);
    io_read(16'h0000, 1, "R9");
    io_read(16'h0001, 7, "R9");
    io_read(16'h0002, 1, "R9");
    // back to flash, new pages
    io_write(16'h0000, 16'h0000);
    io_write(16'h0001, 16'h0003);
    io_write(16'h0002, 16'h0000);
    drive(0, 1, 1, 0, 1, 16'hFFFF, 0, 3);
    drive(1, 0, 1, 0, 1, 16'hFFFF, 0, 2);
    idle(3);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule